// File: doc/BRIEF.md
# Flash Write-Protection and Sector-Permission Unit

This unit guards program and erase traffic to a 512 KB serial flash. It keeps a small status register with a two-bit protect-level field and a lock-down flag. It applies status-write requests subject to a write-protect pin. For every program, sector-erase or chip-erase request it returns a registered verdict: allowed or refused.

Alongside the verdict, it decodes any 19-bit address into the base and byte size of the sector that contains it. The memory is split into seven 64 KB sectors at the bottom. The top 64 KB is split into five smaller sectors, which hold boot code.

Command decoding, the array itself, erase and program timing, and the busy and write-enable state all live elsewhere. They reach this unit as one-cycle request pulses.

Top module: `flash_guard`

## Requirements
- R1: After reset, `sr_o` reads 8'h0C: both protect-level bits (bit 3 and bit 2) are 1 and the lock-down flag (bit 7) is 0. `resp_vld_o` is 0.
- R2: The protect level `{sr_o[3],sr_o[2]}` selects the guarded range:
  - 00 guards nothing.
  - 01 guards 70000h–7FFFFh.
  - 10 guards 60000h–7FFFFh.
  - 11 guards 00000h–7FFFFh.
  
  A program request (`op_kind_i`=0) whose address lies in the guarded range is refused. Any other program request is allowed.
- R3: With `wp_pin_i`=0 and lock-down flag 1, a status write leaves `sr_o` unchanged.
- R4: With `wp_pin_i`=1, or with the lock-down flag at 0, a status write loads bit 7 and bits 3:2 of `sr_wdata_i` into the same positions of the status register.
- R5: A chip erase (`op_kind_i`=2) is allowed only when both protect-level bits are 0.
- R6: A sector erase (`op_kind_i`=1) is refused when any byte of the addressed sector lies in the guarded range. Otherwise it is allowed.
- R7: `sect_base_o` and `sect_size_o` follow `addr_i` combinationally, using this sector map:
  - 8 KB at 7E000h
  - 4 KB at 7D000h
  - 4 KB at 7C000h
  - 16 KB at 78000h
  - 32 KB at 70000h
  - 64 KB at each of 00000h, 10000h, …, 60000h
- R8: A request sampled at a clock edge produces `resp_vld_o`=1 for exactly the following cycle, with `resp_ok_o` holding the verdict. `resp_ok_o` is 0 whenever `resp_vld_o` is 0. The reserved kind 3 is always refused.
- R9: Status bits 6:4 and 1:0 always read 0, whatever value is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wp_pin_i | input | 1 | Write-protect pin level (0 enables lock-down) |
| sr_wr_i | input | 1 | Status-write request pulse |
| sr_wdata_i | input | 8 | Status-write data |
| sr_o | output | 8 | Status register contents |
| op_req_i | input | 1 | Program/erase request pulse |
| op_kind_i | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 reserved |
| addr_i | input | 19 | Target byte address |
| resp_vld_o | output | 1 | Verdict valid, one cycle after a request |
| resp_ok_o | output | 1 | Verdict: 1 allowed, 0 refused |
| sect_base_o | output | 19 | Base address of the sector holding `addr_i` |
| sect_size_o | output | 19 | Byte size of that sector |

## Verification
The assertions take three things for granted:
- `op_req_i` and `sr_wr_i` are single-cycle pulses.
- `addr_i`, `op_kind_i` and `wp_pin_i` hold steady around the sampling edge.
- `op_req_i` stays low while reset is asserted, because the response check compares against the previous cycle.

The bench honours all three. It drives every input on the falling edge and drops each request after one cycle. It never issues a status write and an operation in the same cycle, so each verdict is checked against a protect level that has already settled.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
  localparam int ADDR_W = 19;
  localparam int BLK_W  = 16;   // log2 of the uniform sector size
  localparam int SR_W   = 8;
  localparam int BP_LO  = 2;    // protect level occupies [BP_LO+1:BP_LO]
  localparam int LOCK_B = 7;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_CHIP = 2'd2,
    OP_RSVD = 2'd3
  } op_kind_e;
endpackage

// File: rtl/flash_guard_status.sv
module flash_guard_status
  import flash_guard_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wp_pin_i,
  input  logic            wr_i,
  input  logic [SR_W-1:0] wdata_i,
  output logic [1:0]      level_o,
  output logic            lock_o,
  output logic [SR_W-1:0] sr_o
);
  logic [1:0] level_q;
  logic       lock_q;
  logic       frozen;
  logic [SR_W-4:0] wdata_unused;

  assign frozen = lock_q & ~wp_pin_i;
  assign wdata_unused = {wdata_i[LOCK_B-1:BP_LO+2], wdata_i[BP_LO-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= 2'b11;
      lock_q  <= 1'b0;
    end else if (wr_i && !frozen) begin
      level_q <= wdata_i[BP_LO+1:BP_LO];
      lock_q  <= wdata_i[LOCK_B];
    end
  end

  always_comb begin
    sr_o                   = '0;
    sr_o[BP_LO+1:BP_LO]    = level_q;
    sr_o[LOCK_B]           = lock_q;
  end

  assign level_o = level_q;
  assign lock_o  = lock_q;
endmodule

// File: rtl/flash_guard_region.sv
module flash_guard_region
  import flash_guard_pkg::*;
(
  input  logic [1:0]        level_i,
  output logic              prot_en_o,
  output logic [ADDR_W-1:0] prot_lo_o
);
  localparam int unsigned MEM_BYTES = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LO_EIGHTH  = ADDR_W'(MEM_BYTES - (MEM_BYTES >> 3));
  localparam logic [ADDR_W-1:0] LO_QUARTER = ADDR_W'(MEM_BYTES - (MEM_BYTES >> 2));

  assign prot_en_o = |level_i;

  always_comb begin
    unique case (level_i)
      2'b01:   prot_lo_o = LO_EIGHTH;
      2'b10:   prot_lo_o = LO_QUARTER;
      default: prot_lo_o = '0;   // 11 guards all; 00 gated by prot_en_o
    endcase
  end
endmodule

// File: rtl/flash_guard_sector_map.sv
module flash_guard_sector_map
  import flash_guard_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] size_o
);
  localparam int HI_W = ADDR_W - BLK_W;
  localparam logic [ADDR_W-1:0] SZ_BLK  = ADDR_W'(1) << BLK_W;
  localparam logic [ADDR_W-1:0] SZ_HALF = SZ_BLK >> 1;   // 32 KB
  localparam logic [ADDR_W-1:0] SZ_QTR  = SZ_BLK >> 2;   // 16 KB
  localparam logic [ADDR_W-1:0] SZ_8TH  = SZ_BLK >> 3;   // 8 KB
  localparam logic [ADDR_W-1:0] SZ_16TH = SZ_BLK >> 4;   // 4 KB
  localparam logic [ADDR_W-1:0] TOP_BASE = {{HI_W{1'b1}}, {BLK_W{1'b0}}};

  logic             in_top;
  logic [BLK_W-1:0] off;

  assign in_top = &addr_i[ADDR_W-1:BLK_W];
  assign off    = addr_i[BLK_W-1:0];

  always_comb begin
    if (!in_top) begin
      base_o = {addr_i[ADDR_W-1:BLK_W], {BLK_W{1'b0}}};
      size_o = SZ_BLK;
    end else if (!off[BLK_W-1]) begin
      base_o = TOP_BASE;
      size_o = SZ_HALF;
    end else if (!off[BLK_W-2]) begin
      base_o = TOP_BASE + SZ_HALF;
      size_o = SZ_QTR;
    end else if (!off[BLK_W-3]) begin
      base_o = TOP_BASE + SZ_HALF + SZ_QTR + (off[BLK_W-4] ? SZ_16TH : '0);
      size_o = SZ_16TH;
    end else begin
      base_o = TOP_BASE + SZ_HALF + SZ_QTR + SZ_8TH;
      size_o = SZ_8TH;
    end
  end
endmodule

// File: rtl/flash_guard_verdict.sv
module flash_guard_verdict
  import flash_guard_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [1:0]        kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] sect_base_i,
  input  logic [ADDR_W-1:0] sect_size_i,
  input  logic              prot_en_i,
  input  logic [ADDR_W-1:0] prot_lo_i,
  output logic              vld_o,
  output logic              ok_o
);
  logic [ADDR_W-1:0] sect_last;
  logic              allow;
  op_kind_e          kind;

  assign kind      = op_kind_e'(kind_i);
  assign sect_last = sect_base_i + sect_size_i - ADDR_W'(1);

  always_comb begin
    unique case (kind)
      OP_PROG: allow = !prot_en_i || (addr_i    < prot_lo_i);
      OP_SECT: allow = !prot_en_i || (sect_last < prot_lo_i);
      OP_CHIP: allow = !prot_en_i;
      default: allow = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      ok_o  <= 1'b0;
    end else begin
      vld_o <= req_i;
      ok_o  <= req_i & allow;
    end
  end
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wp_pin_i,
  input  logic              sr_wr_i,
  input  logic [SR_W-1:0]   sr_wdata_i,
  output logic [SR_W-1:0]   sr_o,
  input  logic              op_req_i,
  input  logic [1:0]        op_kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              resp_vld_o,
  output logic              resp_ok_o,
  output logic [ADDR_W-1:0] sect_base_o,
  output logic [ADDR_W-1:0] sect_size_o
);
  logic [1:0]        level;
  logic              lock_unused;
  logic              prot_en;
  logic [ADDR_W-1:0] prot_lo;

  flash_guard_status i_status (
    .clk_i, .rst_ni, .wp_pin_i,
    .wr_i(sr_wr_i), .wdata_i(sr_wdata_i),
    .level_o(level), .lock_o(lock_unused), .sr_o(sr_o)
  );

  flash_guard_region i_region (
    .level_i(level), .prot_en_o(prot_en), .prot_lo_o(prot_lo)
  );

  flash_guard_sector_map i_map (
    .addr_i, .base_o(sect_base_o), .size_o(sect_size_o)
  );

  flash_guard_verdict i_verdict (
    .clk_i, .rst_ni,
    .req_i(op_req_i), .kind_i(op_kind_i), .addr_i,
    .sect_base_i(sect_base_o), .sect_size_i(sect_size_o),
    .prot_en_i(prot_en), .prot_lo_i(prot_lo),
    .vld_o(resp_vld_o), .ok_o(resp_ok_o)
  );
endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk
  import flash_guard_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wp_pin_i,
  input logic              sr_wr_i,
  input logic [SR_W-1:0]   sr_wdata_i,
  input logic [SR_W-1:0]   sr_o,
  input logic              op_req_i,
  input logic [1:0]        op_kind_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              resp_vld_o,
  input logic              resp_ok_o,
  input logic [ADDR_W-1:0] sect_base_o,
  input logic [ADDR_W-1:0] sect_size_o
);
  a_r2_full_guard_refuses_program: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_req_i && op_kind_i == 2'd0 && sr_o[3:2] == 2'b11) |=> !resp_ok_o);

  a_r3_lock_freezes_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_wr_i && !wp_pin_i && sr_o[7]) |=> $stable(sr_o));

  a_r4_open_write_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_wr_i && wp_pin_i) |=>
      (sr_o[7] == $past(sr_wdata_i[7]) && sr_o[3:2] == $past(sr_wdata_i[3:2])));

  a_r5_chip_needs_level_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_req_i && op_kind_i == 2'd2 && sr_o[3:2] != 2'b00) |=> (resp_vld_o && !resp_ok_o));

  a_r7_sector_contains_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, addr_i} >= {1'b0, sect_base_o}) &&
    ({1'b0, addr_i} <  ({1'b0, sect_base_o} + {1'b0, sect_size_o})));

  a_r8_resp_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_req_i |=> resp_vld_o);

  a_r8_no_spurious_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_req_i |=> !resp_vld_o);

  a_r8_ok_only_when_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_ok_o |-> resp_vld_o);

  a_r9_reserved_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_o[6:4] == 3'b000 && sr_o[1:0] == 2'b00));
endmodule

bind flash_guard flash_guard_chk i_flash_guard_chk (.*);

// File: tb/test_flash_guard.sv
module test_flash_guard;
  localparam int AW = 19;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wp_pin_i = 1'b1;
  logic          sr_wr_i = 1'b0;
  logic [7:0]    sr_wdata_i = '0;
  logic [7:0]    sr_o;
  logic          op_req_i = 1'b0;
  logic [1:0]    op_kind_i = '0;
  logic [AW-1:0] addr_i = '0;
  logic          resp_vld_o, resp_ok_o;
  logic [AW-1:0] sect_base_o, sect_size_o;

  int errors = 0;
  int checks = 0;

  always #10 clk_i = ~clk_i;

  flash_guard i_flash_guard (.*);

  typedef struct packed {
    logic [1:0]    lvl;
    logic [1:0]    kind;
    logic [AW-1:0] addr;
    logic          ok;
  } vec_t;

  // kind: 0 program, 1 sector erase, 2 chip erase, 3 reserved
  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd0, 19'h7FFFF, 1'b1},
    '{2'd0, 2'd2, 19'h00000, 1'b1},
    '{2'd0, 2'd1, 19'h00000, 1'b1},
    '{2'd0, 2'd3, 19'h00000, 1'b0},
    '{2'd1, 2'd0, 19'h6FFFF, 1'b1},
    '{2'd1, 2'd0, 19'h70000, 1'b0},
    '{2'd1, 2'd1, 19'h6FFFF, 1'b1},
    '{2'd1, 2'd1, 19'h70000, 1'b0},
    '{2'd1, 2'd1, 19'h7E000, 1'b0},
    '{2'd1, 2'd2, 19'h00000, 1'b0},
    '{2'd2, 2'd0, 19'h5FFFF, 1'b1},
    '{2'd2, 2'd0, 19'h60000, 1'b0},
    '{2'd2, 2'd1, 19'h5FFFF, 1'b1},
    '{2'd2, 2'd1, 19'h60000, 1'b0},
    '{2'd2, 2'd1, 19'h7D000, 1'b0},
    '{2'd2, 2'd2, 19'h00000, 1'b0},
    '{2'd3, 2'd0, 19'h00000, 1'b0},
    '{2'd3, 2'd1, 19'h3FFFF, 1'b0},
    '{2'd3, 2'd2, 19'h00000, 1'b0},
    '{2'd3, 2'd0, 19'h7FFFF, 1'b0}
  };

  localparam int NS = 12;
  localparam logic [AW-1:0] S_BASE [NS] = '{
    19'h00000, 19'h10000, 19'h20000, 19'h30000, 19'h40000, 19'h50000,
    19'h60000, 19'h70000, 19'h78000, 19'h7C000, 19'h7D000, 19'h7E000};
  localparam logic [AW-1:0] S_SIZE [NS] = '{
    19'h10000, 19'h10000, 19'h10000, 19'h10000, 19'h10000, 19'h10000,
    19'h10000, 19'h08000, 19'h04000, 19'h01000, 19'h01000, 19'h02000};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sr_write(input logic wp, input logic [7:0] d);
    @(negedge clk_i);
    wp_pin_i = wp; sr_wr_i = 1'b1; sr_wdata_i = d;
    @(negedge clk_i);
    sr_wr_i = 1'b0;
  endtask

  task automatic issue(input logic [1:0] kind, input logic [AW-1:0] a,
                       output logic vld, output logic ok, output logic vld_after);
    @(negedge clk_i);
    op_req_i = 1'b1; op_kind_i = kind; addr_i = a;
    @(negedge clk_i);
    op_req_i = 1'b0;
    vld = resp_vld_o; ok = resp_ok_o;
    @(negedge clk_i);
    vld_after = resp_vld_o;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic v, k, va;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 reset status", 32'(sr_o), 32'h0C);
    check("R1 reset resp_vld", 32'(resp_vld_o), 32'h0);

    // table walk: set level with the pin high, then issue the request
    for (int i = 0; i < NV; i++) begin
      sr_write(1'b1, {6'b0, VECS[i].lvl} << 2);
      issue(VECS[i].kind, VECS[i].addr, v, k, va);
      check("R8 resp valid", 32'(v), 32'h1);
      check("R8 resp one cycle", 32'(va), 32'h0);
      case (VECS[i].kind)
        2'd0:    check("R2 program verdict", 32'(k), 32'(VECS[i].ok));
        2'd1:    check("R6 sector erase verdict", 32'(k), 32'(VECS[i].ok));
        2'd2:    check("R5 chip erase verdict", 32'(k), 32'(VECS[i].ok));
        default: check("R8 reserved kind refused", 32'(k), 32'(VECS[i].ok));
      endcase
    end

    // lock-down across pin levels
    sr_write(1'b0, 8'h00);
    check("R4 pin low unlocked write", 32'(sr_o), 32'h00);
    sr_write(1'b0, 8'h88);
    check("R4 pin low sets lock", 32'(sr_o), 32'h88);
    sr_write(1'b0, 8'h04);
    check("R3 locked write ignored", 32'(sr_o), 32'h88);
    issue(2'd0, 19'h5FFFF, v, k, va);
    check("R3 level still 10 after locked write", 32'(k), 32'h1);
    sr_write(1'b1, 8'h04);
    check("R4 pin high overrides lock", 32'(sr_o), 32'h04);
    sr_write(1'b1, 8'h7F);
    check("R9 reserved bits read 0", 32'(sr_o), 32'h0C);
    sr_write(1'b1, 8'hF3);
    check("R9 reserved bits ignored", 32'(sr_o), 32'h80);

    // idle: no response without request
    @(negedge clk_i);
    check("R8 no response when idle", 32'(resp_vld_o), 32'h0);

    // sector map: first and last byte of each sector
    for (int s = 0; s < NS; s++) begin
      @(negedge clk_i);
      addr_i = S_BASE[s];
      #1;
      check("R7 base at first byte", 32'(sect_base_o), 32'(S_BASE[s]));
      check("R7 size at first byte", 32'(sect_size_o), 32'(S_SIZE[s]));
      addr_i = S_BASE[s] + S_SIZE[s] - 19'd1;
      #1;
      check("R7 base at last byte", 32'(sect_base_o), 32'(S_BASE[s]));
      check("R7 size at last byte", 32'(sect_size_o), 32'(S_SIZE[s]));
    end

    // reset restores defaults
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 reset after use", 32'(sr_o), 32'h0C);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule